// File: doc/BRIEF.md
# Switch Hot Reset Fan-out Controller

This block sits beside the bridge model of a multi-port packet switch: one upstream bridge above a set of downstream bridges. It watches the upstream port for two hot reset causes. The first is the reset flag carried in received training sets. The second is the upstream link layer dropping from an active state into the inactive state.

When either cause appears, the block starts a reset episode. While the episode lasts, it flushes every queued packet, returns the switch state machines to their defaults and clears the non-sticky register bits. It also asks the link training logic of every downstream port whose link is up to send the reset flag on its own link. Each downstream port gets a short local state clear, whether its link is up or down. Sticky register bits, clocking and port configuration are never touched; the block has no output that reaches them.

An episode lasts at least a set number of cycles. It continues for as long as the upstream cause stays present. When the episode ends, the block emits a single-cycle completion pulse.

Top module: `hot_reset_fanout`

## Requirements
- R1: After `rst_n` is released, and before any trigger, all outputs are 0.
- R2: A cycle with `up_ts_rst` = 1 starts a reset episode. From the next cycle on, `q_flush`, `fsm_rst` and `nonsticky_clr` are all 1 and stay 1 for the whole episode.
- R3: The link state `up_dl_state` uses code 2'b00 for inactive; every other code means active. A move from any active code to 2'b00 starts an episode exactly as in R2. A link that has been inactive since reset does not start one.
- R4: An episode lasts at least `MIN_HOLD` cycles (default 16). A one-cycle trigger gives exactly `MIN_HOLD` cycles of `q_flush` high.
- R5: The episode stays active past the minimum for as long as `up_ts_rst` = 1 or `up_dl_state` = 2'b00.
- R6: A new trigger during an active episode does not restart the minimum count. A single-cycle retrigger inside the minimum window leaves the length at `MIN_HOLD`.
- R7: `ds_hot_rst[i]` is 1 exactly in the episode cycles where `ds_link_up[i]` = 1. A port whose link is down gets no request.
- R8: `ds_state_clr[i]` is 1 for `CLR_BASE + i` cycles (default CLR_BASE = 2), starting in the first cycle of the episode. This happens regardless of `ds_link_up[i]`.
- R9: `rst_done` pulses 1 for exactly one cycle: the first cycle after the episode ends. The episode ends only once every port clear is finished and the trigger level is gone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| up_ts_rst | input | 1 | Reset flag from received upstream training sets |
| up_dl_state | input | 2 | Upstream link layer state, 2'b00 = inactive |
| ds_link_up | input | NUM_DS | Per downstream port link-up |
| ds_hot_rst | output | NUM_DS | Per port request to send the reset flag in training sets |
| ds_state_clr | output | NUM_DS | Per port internal state clear |
| q_flush | output | 1 | Discard all queued packets |
| fsm_rst | output | 1 | Return state machines to defaults |
| nonsticky_clr | output | 1 | Clear non-sticky register bits |
| rst_done | output | 1 | One-cycle episode completion pulse |

## Verification
The hardest case to reach from the ports is a retrigger that lands inside the minimum window of an episode already running. A restarting design and an extending design look identical unless the second trigger comes late enough to push past `MIN_HOLD`, but is short enough to expire before the minimum ends. A directed sequence fires a training-set pulse ten cycles into an episode and measures its length. A randomized phase then mixes sparse flag pulses, link drops and link-up patterns, and compares every output against a cycle model in the bench.

// File: rtl/hrst_pkg.sv
package hrst_pkg;
  typedef logic [1:0] dl_state_t;
  localparam dl_state_t DL_INACTIVE = 2'b00;

  // length of the local state clear of downstream port idx
  function automatic int unsigned clr_len(input int unsigned base, input int unsigned idx);
    return base + idx;
  endfunction

  // minimum hold reached once the counter has seen min_hold active cycles
  function automatic logic hold_reached(input int unsigned cnt, input int unsigned min_hold);
    return cnt >= min_hold;
  endfunction
endpackage

// File: rtl/hrst_trig_detect.sv
module hrst_trig_detect
  import hrst_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      ts_rst,
  input  dl_state_t dl_state,
  output logic      trig_start,
  output logic      trig_level
);
  logic dl_up, dl_up_q;

  assign dl_up = (dl_state != DL_INACTIVE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dl_up_q <= 1'b0;
    else        dl_up_q <= dl_up;
  end

  // R2 flag or R3 active-to-inactive edge
  assign trig_start = ts_rst | (dl_up_q & ~dl_up);
  // R5 level that keeps an episode alive
  assign trig_level = ts_rst | ~dl_up;
endmodule

// File: rtl/hrst_port_clear.sv
module hrst_port_clear #(
  parameter int unsigned LEN = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic kick,
  output logic busy
);
  localparam int unsigned CW = $clog2(LEN + 1);
  logic [CW-1:0] left_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              left_q <= '0;
    else if (kick)           left_q <= CW'(LEN);
    else if (left_q != '0)   left_q <= left_q - 1'b1;
  end

  assign busy = (left_q != '0);
endmodule

// File: rtl/hrst_hold_ctrl.sv
module hrst_hold_ctrl
  import hrst_pkg::*;
#(
  parameter int unsigned MIN_HOLD = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trig_start,
  input  logic trig_level,
  input  logic clr_all_done,
  output logic active,
  output logic kick,
  output logic done
);
  localparam int unsigned CW = $clog2(MIN_HOLD + 1);
  logic [CW-1:0] cnt_q;
  logic          hold_met;

  assign hold_met = hold_reached(int'(cnt_q), MIN_HOLD);
  assign kick     = trig_start & ~active;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      cnt_q  <= '0;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!active) begin
        if (trig_start) begin
          active <= 1'b1;
          cnt_q  <= CW'(1);
        end
      end else if (!hold_met) begin
        cnt_q <= cnt_q + 1'b1;
      end else if (!trig_level && clr_all_done) begin
        active <= 1'b0;
        done   <= 1'b1;
      end
    end
  end

  a_r2_start: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_start && !active) |=> active);
  a_r5_extend: assert property (@(posedge clk) disable iff (!rst_n)
    (active && trig_level) |=> active);
  a_r4_min_hold: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(active) |-> $past(hold_met));
  a_r9_done_after: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!active && $past(active)));
  a_r9_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

// File: rtl/hot_reset_fanout.sv
module hot_reset_fanout
  import hrst_pkg::*;
#(
  parameter int unsigned NUM_DS   = 4,
  parameter int unsigned MIN_HOLD = 16,
  parameter int unsigned CLR_BASE = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              up_ts_rst,
  input  logic [1:0]        up_dl_state,
  input  logic [NUM_DS-1:0] ds_link_up,
  output logic [NUM_DS-1:0] ds_hot_rst,
  output logic [NUM_DS-1:0] ds_state_clr,
  output logic              q_flush,
  output logic              fsm_rst,
  output logic              nonsticky_clr,
  output logic              rst_done
);
  logic trig_start, trig_level;
  logic active, kick, clr_all_done;

  hrst_trig_detect u_trig (
    .clk(clk), .rst_n(rst_n), .ts_rst(up_ts_rst), .dl_state(up_dl_state),
    .trig_start(trig_start), .trig_level(trig_level)
  );

  hrst_hold_ctrl #(.MIN_HOLD(MIN_HOLD)) u_hold (
    .clk(clk), .rst_n(rst_n), .trig_start(trig_start), .trig_level(trig_level),
    .clr_all_done(clr_all_done), .active(active), .kick(kick), .done(rst_done)
  );

  for (genvar i = 0; i < NUM_DS; i++) begin : g_port
    hrst_port_clear #(.LEN(clr_len(CLR_BASE, i))) u_clr (
      .clk(clk), .rst_n(rst_n), .kick(kick), .busy(ds_state_clr[i])
    );
    // R7: only ports with a live link carry the flag downstream
    assign ds_hot_rst[i] = active & ds_link_up[i];
  end

  assign clr_all_done  = ~|ds_state_clr;
  assign q_flush       = active;
  assign fsm_rst       = active;
  assign nonsticky_clr = active;

  a_r8_clear_starts: assert property (@(posedge clk) disable iff (!rst_n)
    kick |=> (ds_state_clr[0] && q_flush));
  a_r7_link_down_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !q_flush |-> (ds_hot_rst == '0));
  a_r1_idle_no_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (!q_flush && !$past(q_flush)) |-> (ds_state_clr == '0));
endmodule

// File: tb/sim_hot_reset_fanout.sv
`timescale 1ns/1ps
module sim_hot_reset_fanout;
  localparam int NP = 4;
  localparam int MH = 16;
  localparam int CB = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          ts = 1'b0;
  logic [1:0]    dl = 2'b00;
  logic [NP-1:0] lup = '0;
  logic [NP-1:0] hrst, sclr;
  logic          flush, fsmr, nsclr, done;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;
  bit cmp_en = 1'b0;

  always #2.5 clk = ~clk;

  hot_reset_fanout #(.NUM_DS(NP), .MIN_HOLD(MH), .CLR_BASE(CB)) u0 (
    .clk(clk), .rst_n(rst_n), .up_ts_rst(ts), .up_dl_state(dl), .ds_link_up(lup),
    .ds_hot_rst(hrst), .ds_state_clr(sclr), .q_flush(flush), .fsm_rst(fsmr),
    .nonsticky_clr(nsclr), .rst_done(done)
  );

  // cycle model built from the requirements
  bit m_act, m_done, m_prev_up;
  int m_left;
  int m_clr [NP];

  function automatic int port_len(input int i);
    return CB + i;
  endfunction

  function automatic bit clears_idle();
    for (int i = 0; i < NP; i++) if (m_clr[i] != 0) return 1'b0;
    return 1'b1;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_act <= 0; m_done <= 0; m_prev_up <= 0; m_left <= 0;
      for (int i = 0; i < NP; i++) m_clr[i] <= 0;
    end else begin
      bit start, lvl;
      start = ts | (m_prev_up & (dl == 2'b00));
      lvl   = ts | (dl == 2'b00);
      m_prev_up <= (dl != 2'b00);
      m_done <= 0;
      for (int i = 0; i < NP; i++) if (m_clr[i] > 0) m_clr[i] <= m_clr[i] - 1;
      if (!m_act) begin
        if (start) begin
          m_act  <= 1;
          m_left <= MH - 1;
          for (int i = 0; i < NP; i++) m_clr[i] <= port_len(i);
        end
      end else if (m_left > 0) begin
        m_left <= m_left - 1;
      end else if (!lvl && clears_idle()) begin
        m_act  <= 0;
        m_done <= 1;
      end
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  logic [NP-1:0] e_clr;
  always @(negedge clk) begin
    if (cmp_en) begin
      for (int i = 0; i < NP; i++) e_clr[i] = (m_clr[i] != 0);
      chk("R2 flush", flush, m_act);
      chk("R2 fsm/nonsticky", {fsmr, nsclr}, {m_act, m_act});
      chk("R7 ds_hot_rst", hrst, {NP{m_act}} & lup);
      chk("R8 ds_state_clr", sclr, e_clr);
      chk("R9 rst_done", done, m_done);
    end
  end

  task automatic wait_idle();
    int n = 0;
    while ((flush || done) && n < 500) begin @(negedge clk); n++; end
    repeat (3) @(negedge clk);
  endtask

  int len;
  int clr_len0;
  int done_seen;

  initial begin
    repeat (3) @(negedge clk);
    // R1: outputs during and right after reset
    chk("R1 reset", {hrst, sclr, flush, fsmr, nsclr, done}, '0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R3: link inactive since reset starts nothing
    chk("R1 idle R3", {hrst, sclr, flush, done}, '0);
    cmp_en = 1'b1;
    dl = 2'b11; lup = 4'b1111;
    repeat (2) @(negedge clk);

    // R4: single-cycle flag gives exactly MH cycles
    ts = 1'b1; @(negedge clk); ts = 1'b0;
    len = 0; clr_len0 = 0; done_seen = 0;
    while (flush && len < 200) begin
      if (sclr[0]) clr_len0++;
      len++; @(negedge clk);
    end
    chk("R4 min length", len, MH);
    chk("R8 port0 clear length", clr_len0, CB);
    chk("R9 done after end", done, 1);
    @(negedge clk);
    chk("R9 done one cycle", done, 0);
    wait_idle();

    // R6: retrigger inside window does not restart
    ts = 1'b1; @(negedge clk); ts = 1'b0;
    len = 0;
    while (flush && len < 200) begin
      ts = (len == 10);
      len++; @(negedge clk);
    end
    ts = 1'b0;
    chk("R6 no restart", len, MH);
    wait_idle();

    // R3 + R5: link drop held 30 cycles keeps episode alive
    lup = 4'b0101;
    dl = 2'b00;
    repeat (30) @(negedge clk);
    chk("R5 held while inactive", flush, 1);
    chk("R7 link-down ports quiet", hrst, 4'b0101);
    dl = 2'b01;
    len = 0;
    while (flush && len < 200) begin len++; @(negedge clk); end
    chk("R5 ends once level gone", len, 1);
    wait_idle();

    // R5: long flag beyond minimum
    lup = 4'b1111;
    ts = 1'b1; repeat (25) @(negedge clk);
    chk("R5 held by flag", flush, 1);
    ts = 1'b0;
    wait_idle();

    // random mix checked against the model
    void'($urandom(32'h5eed_1234));
    for (int k = 0; k < 3000; k++) begin
      ts  = ($urandom_range(0, 19) == 0);
      dl  = ($urandom_range(0, 39) == 0) ? 2'b00 : 2'($urandom_range(1, 3));
      if ($urandom_range(0, 15) == 0) lup = NP'($urandom);
      @(negedge clk);
    end
    ts = 1'b0; dl = 2'b10;
    wait_idle();

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule